// File: doc/BRIEF.md
# Instruction Pair Dependence Classifier

This block keeps a short window of decoded instructions in program order and reports, for every ordered pair of them, whether the younger one depends on the older one. Each instruction carries one destination and two source register specifiers, and each specifier has its own valid flag. For every pair the block reports three separate results:

- a true dependence, where the younger instruction reads a register that the older one writes;
- a read-then-overwrite name dependence, where the younger instruction writes a register that the older one reads;
- a double-write name dependence, where both instructions write the same register.

From these results the block also gives a per-slot flag. The flag says whether the instruction could go ahead of older instructions that are stalled.

Instructions enter through a valid/ready port, one per cycle, strictly in program order. Slot 0 always holds the oldest instruction. A plain `retire` pin removes the head, and the remaining entries, with all their matrix rows and columns, move down by one slot on the next cycle. The `renamed_mode` pin states that renaming downstream removes name dependences. In that mode only true dependences clear the early-issue flag, while all three matrices are still reported.

Top module: `dep_classifier`

## Requirements
- R1: `in_ready` is high while the window holds fewer than DEPTH entries, or when `retire` is high and slot 0 is occupied. A transfer happens when `in_valid` and `in_ready` are both high at a clock edge, and it appends the instruction behind the youngest entry present. The upstream side must hold its data while `in_ready` is low.
- R2: `retire` with slot 0 occupied removes the oldest entry at the clock edge. `retire` on an empty window has no effect. `slot_vld` is always a contiguous run of ones starting at bit 0.
- R3: `raw_mat` bit [i*DEPTH+j] is 1 exactly when j<i, both slots are occupied, and a valid source of slot i equals the valid destination of slot j.
- R4: `war_mat` bit [i*DEPTH+j] is 1 exactly when j<i, both slots are occupied, and the valid destination of slot i equals a valid source of slot j.
- R5: `waw_mat` bit [i*DEPTH+j] is 1 exactly when j<i, both slots are occupied, and both destinations are valid and equal.
- R6: A specifier whose valid flag is clear takes part in no comparison. Register 0 compares like any other register.
- R7: In all three matrices, every bit with j>=i, and every bit that involves an empty slot, is 0.
- R8: With `renamed_mode`=0, `early_ok[i]` is 1 exactly when slot i is occupied and row i is all zero in all three matrices.
- R9: With `renamed_mode`=1, `early_ok[i]` is 1 exactly when slot i is occupied and row i of `raw_mat` is all zero. Name dependences are still reported in their matrices.
- R10: After a retire that is not joined by a push, bit [i*DEPTH+j] of each matrix equals the bit [(i+1)*DEPTH+j+1] it held in the cycle before.
- R11: After reset the window is empty, all matrices and `early_ok` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The window can accept the offered instruction |
| in_dst | input | REG_W | Destination register specifier |
| in_dst_vld | input | 1 | The instruction writes `in_dst` |
| in_src_a | input | REG_W | First source register specifier |
| in_src_a_vld | input | 1 | The instruction reads `in_src_a` |
| in_src_b | input | REG_W | Second source register specifier |
| in_src_b_vld | input | 1 | The instruction reads `in_src_b` |
| retire | input | 1 | Remove the oldest entry at the next edge |
| renamed_mode | input | 1 | Name dependences do not block early issue |
| slot_vld | output | DEPTH | Occupied slots; bit 0 is the oldest |
| raw_mat | output | DEPTH*DEPTH | True-dependence matrix, bit row*DEPTH+col |
| war_mat | output | DEPTH*DEPTH | Read-then-overwrite matrix |
| waw_mat | output | DEPTH*DEPTH | Double-write matrix |
| early_ok | output | DEPTH | Slot may pass stalled older instructions |

## Verification
The bench builds the block with its defaults, an 8-slot window and 5-bit specifiers. It draws register numbers from only 0 to 3, plus a few directed uses of register 0 and of cleared valid flags, so that collisions in all three matrices are frequent. The 8-slot window lets the bench fill the window completely, where a push is accepted only alongside a retire, and also drain it to empty. The shift behaviour is then observed across every row of a full 8x8 triangle, with the issue mode alternating between phases.

// File: rtl/dep_pkg.sv
package dep_pkg;

  // Widest register specifier the comparison helper accepts.
  localparam int SPEC_MAX_W = 8;

  typedef enum logic {
    ISSUE_STRICT  = 1'b0,  // every dependence kind blocks early issue
    ISSUE_RENAMED = 1'b1   // only true dependences block early issue
  } issue_policy_e;

  // Two specifiers refer to the same register and both are in use.
  function automatic logic spec_hit(input logic [SPEC_MAX_W-1:0] x, input logic x_use,
                                    input logic [SPEC_MAX_W-1:0] y, input logic y_use);
    return x_use && y_use && (x == y);
  endfunction

endpackage

// File: rtl/dep_window.sv
module dep_window #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic                        pop,
  input  logic [REG_W-1:0]            new_dst,
  input  logic                        new_dst_v,
  input  logic [REG_W-1:0]            new_sa,
  input  logic                        new_sa_v,
  input  logic [REG_W-1:0]            new_sb,
  input  logic                        new_sb_v,
  output logic [DEPTH-1:0]            occ,
  output logic [DEPTH-1:0][REG_W-1:0] dst,
  output logic [DEPTH-1:0]            dst_v,
  output logic [DEPTH-1:0][REG_W-1:0] sa,
  output logic [DEPTH-1:0]            sa_v,
  output logic [DEPTH-1:0][REG_W-1:0] sb,
  output logic [DEPTH-1:0]            sb_v,
  output logic                        full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]            cnt_q, cnt_d, tail;
  logic [DEPTH-1:0]            occ_q, occ_d;
  logic [DEPTH-1:0][REG_W-1:0] dst_q, dst_d, sa_q, sa_d, sb_q, sb_d;
  logic [DEPTH-1:0]            dv_q, dv_d, av_q, av_d, bv_q, bv_d;
  logic                        pop_go;

  assign pop_go = pop && occ_q[0];
  assign tail   = cnt_q - CNT_W'(pop_go);

  always_comb begin
    occ_d = occ_q;
    dst_d = dst_q; dv_d = dv_q;
    sa_d  = sa_q;  av_d = av_q;
    sb_d  = sb_q;  bv_d = bv_q;
    cnt_d = cnt_q;
    if (pop_go) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        occ_d[k] = occ_q[k+1];
        dst_d[k] = dst_q[k+1]; dv_d[k] = dv_q[k+1];
        sa_d[k]  = sa_q[k+1];  av_d[k] = av_q[k+1];
        sb_d[k]  = sb_q[k+1];  bv_d[k] = bv_q[k+1];
      end
      occ_d[DEPTH-1] = 1'b0;
      dv_d[DEPTH-1]  = 1'b0;
      av_d[DEPTH-1]  = 1'b0;
      bv_d[DEPTH-1]  = 1'b0;
      cnt_d = cnt_d - 1'b1;
    end
    if (push) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (tail == CNT_W'(k)) begin
          occ_d[k] = 1'b1;
          dst_d[k] = new_dst; dv_d[k] = new_dst_v;
          sa_d[k]  = new_sa;  av_d[k] = new_sa_v;
          sb_d[k]  = new_sb;  bv_d[k] = new_sb_v;
        end
      end
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      occ_q <= '0;
      dst_q <= '0; dv_q <= '0;
      sa_q  <= '0; av_q <= '0;
      sb_q  <= '0; bv_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      occ_q <= occ_d;
      dst_q <= dst_d; dv_q <= dv_d;
      sa_q  <= sa_d;  av_q <= av_d;
      sb_q  <= sb_d;  bv_q <= bv_d;
    end
  end

  assign occ   = occ_q;
  assign dst   = dst_q;
  assign dst_v = dv_q;
  assign sa    = sa_q;
  assign sa_v  = av_q;
  assign sb    = sb_q;
  assign sb_v  = bv_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));

  logic [DEPTH:0] occ_plus1;
  assign occ_plus1 = {1'b0, occ_q} + 1'b1;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_count_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ_q) == int'(cnt_q));
  p_occ_packed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_plus1[DEPTH-1:0] & occ_q) == '0);
  p_empty_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !occ_q[0] && !push) |=> $stable(occ_q));
  p_retire_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && occ_q[0] && !push) |=> occ_q == ($past(occ_q) >> 1));

endmodule

// File: rtl/dep_pair_cmp.sv
module dep_pair_cmp #(
  parameter int REG_W = 5
) (
  input  logic             young_occ,
  input  logic [REG_W-1:0] young_dst,
  input  logic             young_dst_v,
  input  logic [REG_W-1:0] young_sa,
  input  logic             young_sa_v,
  input  logic [REG_W-1:0] young_sb,
  input  logic             young_sb_v,
  input  logic             old_occ,
  input  logic [REG_W-1:0] old_dst,
  input  logic             old_dst_v,
  input  logic [REG_W-1:0] old_sa,
  input  logic             old_sa_v,
  input  logic [REG_W-1:0] old_sb,
  input  logic             old_sb_v,
  output logic             raw,
  output logic             war,
  output logic             waw
);
  import dep_pkg::*;

  localparam int W = SPEC_MAX_W;

  logic both;
  assign both = young_occ && old_occ;

  // younger reads what older writes
  assign raw = both && (spec_hit(W'(young_sa), young_sa_v, W'(old_dst), old_dst_v) ||
                        spec_hit(W'(young_sb), young_sb_v, W'(old_dst), old_dst_v));
  // younger writes what older reads
  assign war = both && (spec_hit(W'(young_dst), young_dst_v, W'(old_sa), old_sa_v) ||
                        spec_hit(W'(young_dst), young_dst_v, W'(old_sb), old_sb_v));
  // both write the same register
  assign waw = both && spec_hit(W'(young_dst), young_dst_v, W'(old_dst), old_dst_v);

endmodule

// File: rtl/dep_issue_gate.sv
module dep_issue_gate #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH*DEPTH-1:0] raw,
  input  logic [DEPTH*DEPTH-1:0] war,
  input  logic [DEPTH*DEPTH-1:0] waw,
  input  logic [DEPTH-1:0]       occ,
  input  logic                   renamed,
  output logic [DEPTH-1:0]       early
);
  import dep_pkg::*;

  issue_policy_e policy;
  assign policy = issue_policy_e'(renamed);

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic true_dep, name_dep;
    assign true_dep = |raw[i*DEPTH +: DEPTH];
    assign name_dep = |war[i*DEPTH +: DEPTH] || |waw[i*DEPTH +: DEPTH];
    assign early[i] = occ[i] && !true_dep && !(policy == ISSUE_STRICT && name_dep);
  end

endmodule

// File: rtl/dep_classifier.sv
module dep_classifier #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [REG_W-1:0]       in_dst,
  input  logic                   in_dst_vld,
  input  logic [REG_W-1:0]       in_src_a,
  input  logic                   in_src_a_vld,
  input  logic [REG_W-1:0]       in_src_b,
  input  logic                   in_src_b_vld,
  input  logic                   retire,
  input  logic                   renamed_mode,
  output logic [DEPTH-1:0]       slot_vld,
  output logic [DEPTH*DEPTH-1:0] raw_mat,
  output logic [DEPTH*DEPTH-1:0] war_mat,
  output logic [DEPTH*DEPTH-1:0] waw_mat,
  output logic [DEPTH-1:0]       early_ok
);
  logic [DEPTH-1:0]            occ;
  logic [DEPTH-1:0][REG_W-1:0] dst, sa, sb;
  logic [DEPTH-1:0]            dst_v, sa_v, sb_v;
  logic                        full, push_fire, pop_fire;

  assign pop_fire  = retire && occ[0];
  assign in_ready  = !full || pop_fire;
  assign push_fire = in_valid && in_ready;

  dep_window #(.DEPTH(DEPTH), .REG_W(REG_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_fire),
    .pop       (retire),
    .new_dst   (in_dst),
    .new_dst_v (in_dst_vld),
    .new_sa    (in_src_a),
    .new_sa_v  (in_src_a_vld),
    .new_sb    (in_src_b),
    .new_sb_v  (in_src_b_vld),
    .occ       (occ),
    .dst       (dst),
    .dst_v     (dst_v),
    .sa        (sa),
    .sa_v      (sa_v),
    .sb        (sb),
    .sb_v      (sb_v),
    .full      (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_young
    for (genvar j = 0; j < DEPTH; j++) begin : g_old
      if (j < i) begin : g_cmp
        dep_pair_cmp #(.REG_W(REG_W)) u_cmp (
          .young_occ   (occ[i]),
          .young_dst   (dst[i]),
          .young_dst_v (dst_v[i]),
          .young_sa    (sa[i]),
          .young_sa_v  (sa_v[i]),
          .young_sb    (sb[i]),
          .young_sb_v  (sb_v[i]),
          .old_occ     (occ[j]),
          .old_dst     (dst[j]),
          .old_dst_v   (dst_v[j]),
          .old_sa      (sa[j]),
          .old_sa_v    (sa_v[j]),
          .old_sb      (sb[j]),
          .old_sb_v    (sb_v[j]),
          .raw         (raw_mat[i*DEPTH+j]),
          .war         (war_mat[i*DEPTH+j]),
          .waw         (waw_mat[i*DEPTH+j])
        );
      end else begin : g_zero
        assign raw_mat[i*DEPTH+j] = 1'b0;
        assign war_mat[i*DEPTH+j] = 1'b0;
        assign waw_mat[i*DEPTH+j] = 1'b0;
      end
    end
  end

  dep_issue_gate #(.DEPTH(DEPTH)) u_gate (
    .raw     (raw_mat),
    .war     (war_mat),
    .waw     (waw_mat),
    .occ     (occ),
    .renamed (renamed_mode),
    .early   (early_ok)
  );

  assign slot_vld = occ;

  p_ready_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> in_ready);
  p_head_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ[0] |-> early_ok[0]);
  p_empty_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !occ[0] |-> (raw_mat == '0 && war_mat == '0 && waw_mat == '0 && early_ok == '0));

  // R10: every surviving pair keeps its bits after moving down one slot
  for (genvar i = 1; i < DEPTH - 1; i++) begin : g_chk_row
    for (genvar j = 0; j < i; j++) begin : g_chk_col
      p_follow_raw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && !push_fire) |=> raw_mat[i*DEPTH+j] == $past(raw_mat[(i+1)*DEPTH+j+1]));
      p_follow_war_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && !push_fire) |=> war_mat[i*DEPTH+j] == $past(war_mat[(i+1)*DEPTH+j+1]));
      p_follow_waw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && !push_fire) |=> waw_mat[i*DEPTH+j] == $past(waw_mat[(i+1)*DEPTH+j+1]));
    end
  end

endmodule

// File: tb/test_dep_classifier.sv
module test_dep_classifier;
  localparam int DEPTH = 8;
  localparam int REG_W = 5;
  localparam int N     = DEPTH * DEPTH;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, in_valid, in_ready, retire, renamed_mode;
  logic [REG_W-1:0] in_dst, in_src_a, in_src_b;
  logic             in_dst_vld, in_src_a_vld, in_src_b_vld;
  logic [DEPTH-1:0] slot_vld, early_ok;
  logic [N-1:0]     raw_mat, war_mat, waw_mat;

  dep_classifier #(.DEPTH(DEPTH), .REG_W(REG_W)) i_dep_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_dst_vld(in_dst_vld), .in_src_a(in_src_a),
    .in_src_a_vld(in_src_a_vld), .in_src_b(in_src_b), .in_src_b_vld(in_src_b_vld),
    .retire(retire), .renamed_mode(renamed_mode), .slot_vld(slot_vld),
    .raw_mat(raw_mat), .war_mat(war_mat), .waw_mat(waw_mat), .early_ok(early_ok)
  );

  typedef struct packed {
    logic [REG_W-1:0] d; logic dv;
    logic [REG_W-1:0] a; logic av;
    logic [REG_W-1:0] b; logic bv;
  } ent_t;

  ent_t         mq[$];
  int           checks = 0;
  int           errors = 0;
  logic [N-1:0] e_raw, e_war, e_waw, upper;
  logic [N-1:0] prev_raw, prev_war, prev_waw;
  logic [DEPTH-1:0] e_vld, e_early;
  logic         e_ready;
  logic         prev_shift = 1'b0;

  function automatic logic hit(logic [REG_W-1:0] x, logic xv, logic [REG_W-1:0] y, logic yv);
    return xv && yv && (x == y);
  endfunction

  task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_eval();
    e_raw = '0; e_war = '0; e_waw = '0; e_vld = '0; e_early = '0;
    for (int i = 0; i < mq.size(); i++) begin
      e_vld[i] = 1'b1;
      for (int j = 0; j < i; j++) begin
        e_raw[i*DEPTH+j] = hit(mq[i].a, mq[i].av, mq[j].d, mq[j].dv) ||
                           hit(mq[i].b, mq[i].bv, mq[j].d, mq[j].dv);
        e_war[i*DEPTH+j] = hit(mq[i].d, mq[i].dv, mq[j].a, mq[j].av) ||
                           hit(mq[i].d, mq[i].dv, mq[j].b, mq[j].bv);
        e_waw[i*DEPTH+j] = hit(mq[i].d, mq[i].dv, mq[j].d, mq[j].dv);
      end
    end
    for (int i = 0; i < mq.size(); i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (e_raw[i*DEPTH+j]) blk = 1'b1;
        if (!renamed_mode && (e_war[i*DEPTH+j] || e_waw[i*DEPTH+j])) blk = 1'b1;
      end
      e_early[i] = !blk;
    end
    e_ready = (mq.size() < DEPTH) || (retire && mq.size() > 0);
  endtask

  task automatic step(input logic v, input ent_t e, input logic r, input logic md);
    logic acc, popd;
    logic [N-1:0] sh;
    @(negedge clk);
    in_valid = v; retire = r; renamed_mode = md;
    in_dst = e.d; in_dst_vld = e.dv; in_src_a = e.a; in_src_a_vld = e.av;
    in_src_b = e.b; in_src_b_vld = e.bv;
    #1;
    model_eval();
    chk("R1 in_ready", N'(in_ready), N'(e_ready));
    chk("R2 slot_vld", N'(slot_vld), N'(e_vld));
    chk("R3 raw_mat", raw_mat, e_raw);
    chk("R4 war_mat", war_mat, e_war);
    chk("R5 waw_mat", waw_mat, e_waw);
    chk("R7 upper triangle", (raw_mat | war_mat | waw_mat) & upper, '0);
    if (md) chk("R9 early_ok renamed", N'(early_ok), N'(e_early));
    else    chk("R8 early_ok strict", N'(early_ok), N'(e_early));
    if (prev_shift) begin
      for (int m = 0; m < 3; m++) begin
        logic [N-1:0] pv, cur;
        pv  = (m == 0) ? prev_raw : (m == 1) ? prev_war : prev_waw;
        cur = (m == 0) ? raw_mat  : (m == 1) ? war_mat  : waw_mat;
        sh = '0;
        for (int i = 0; i < DEPTH - 1; i++)
          for (int j = 0; j < i; j++)
            sh[i*DEPTH+j] = pv[(i+1)*DEPTH+j+1];
        chk("R10 matrix follows shift", cur, sh);
      end
    end
    prev_raw = raw_mat; prev_war = war_mat; prev_waw = waw_mat;
    @(posedge clk);
    acc  = v && e_ready;
    popd = r && (mq.size() > 0);
    if (popd) void'(mq.pop_front());
    if (acc) mq.push_back(e);
    prev_shift = popd && !acc;
  endtask

  function automatic ent_t rnd_ent();
    ent_t e;
    e.d  = REG_W'($urandom_range(0, 3)); e.dv = ($urandom_range(0, 3) != 0);
    e.a  = REG_W'($urandom_range(0, 3)); e.av = ($urandom_range(0, 3) != 0);
    e.b  = REG_W'($urandom_range(0, 3)); e.bv = ($urandom_range(0, 3) != 0);
    return e;
  endfunction

  function automatic ent_t mk(int d, bit dv, int a, bit av, int b, bit bv);
    ent_t e;
    e.d = REG_W'(d); e.dv = dv; e.a = REG_W'(a); e.av = av; e.b = REG_W'(b); e.bv = bv;
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    upper = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = i; j < DEPTH; j++) upper[i*DEPTH+j] = 1'b1;
    rst_n = 1'b0; in_valid = 1'b0; retire = 1'b0; renamed_mode = 1'b0;
    in_dst = '0; in_dst_vld = 1'b0; in_src_a = '0; in_src_a_vld = 1'b0;
    in_src_b = '0; in_src_b_vld = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    chk("R11 slot_vld", N'(slot_vld), '0);
    chk("R11 matrices", raw_mat | war_mat | waw_mat, '0);
    chk("R11 early_ok", N'(early_ok), '0);
    chk("R11 in_ready", N'(in_ready), N'(1'b1));

    // R2: retire on empty window is ignored
    step(1'b0, mk(0,0,0,0,0,0), 1'b1, 1'b0);
    step(1'b0, mk(0,0,0,0,0,0), 1'b0, 1'b0);

    // R6: register 0 compares normally; cleared flags never match
    step(1'b1, mk(0,1, 0,0, 0,0), 1'b0, 1'b0);
    step(1'b1, mk(7,1, 0,1, 3,0), 1'b0, 1'b0);
    step(1'b1, mk(0,0, 0,0, 5,1), 1'b0, 1'b0);
    step(1'b0, mk(0,0,0,0,0,0), 1'b0, 1'b0);
    chk("R6 r0 source hits r0 dest", N'(raw_mat[1*DEPTH+0]), N'(1'b1));
    chk("R6 cleared source no raw", N'(raw_mat[2*DEPTH+0]), N'(1'b0));
    chk("R6 cleared dest no waw", N'(waw_mat[2*DEPTH+0]), N'(1'b0));
    chk("R6 cleared sources no war", N'(war_mat[1*DEPTH+0]), N'(1'b0));
    chk("R8 blocked slot 1", N'(early_ok), N'(8'b0000_0101));
    while (mq.size() > 0) step(1'b0, mk(0,0,0,0,0,0), 1'b1, 1'b0);

    // random phases: fill-heavy, drain-heavy, balanced; mode alternates
    for (int ph = 0; ph < 6; ph++) begin
      for (int n = 0; n < 400; n++) begin
        logic v, r;
        case (ph % 3)
          0: begin v = ($urandom_range(0, 9) < 8); r = ($urandom_range(0, 9) < 2); end
          1: begin v = ($urandom_range(0, 9) < 2); r = ($urandom_range(0, 9) < 7); end
          default: begin v = ($urandom_range(0, 1) == 1); r = ($urandom_range(0, 1) == 1); end
        endcase
        step(v, rnd_ent(), r, ph[0]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule